// File: doc/BRIEF.md
# SD SPI Command Engine

This block runs one complete command exchange with an SD card in SPI mode. It sits behind a byte-wide SPI master and talks to it through a request/acknowledge handshake. Each transfer carries one transmit byte out and one received byte back. A one-cycle `start` latches a 6-bit command index, a 32-bit argument and a count of extra response bytes, and the engine then works through the exchange on its own.

The exchange has five phases:

1. **Ready flush.** The engine clocks 0xFF until the card answers 0xFF.
2. **Frame.** It sends the 6-byte command frame, with the CRC7 computed in hardware.
3. **R1 poll.** It sends 0xFF for a bounded number of polls, waiting for a byte with bit 7 clear.
4. **Trailing bytes.** It collects any further response bytes.
5. **Pad.** It sends one more 0xFF so the card receives eight spare clocks before the next command.

The result appears with a single-cycle `done` pulse. The R1 byte, the extended response and the `timeout` flag then stay valid until the next accepted `start`.

The state machine has seven states:

| State | What happens | Transitions |
|---|---|---|
| IDLE | Waits for work. | `start` leads to FLUSH. |
| FLUSH | Sends 0xFF bytes. | A 0xFF reply leads to FRAME. The limit reached without one leads to FINISH with timeout. |
| FRAME | Sends the six frame bytes. | The sixth byte leads to POLL. |
| POLL | Sends 0xFF and watches each reply. | A reply with bit 7 clear leads to EXT, or to PAD if no extra bytes were asked for. The poll limit reached leads to FINISH with timeout. |
| EXT | Collects the extra response bytes. | The last extra byte leads to PAD. |
| PAD | Sends the trailing 0xFF. | One transfer leads to FINISH. |
| FINISH | Pulses `done`. | Always returns to IDLE. |

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset `spi_req`, `busy`, `done` and `timeout` are 0, `r1` reads 0xFF and `resp_ext` reads 0.
- R2: Every byte sent outside the command frame is 0xFF. The ready flush ends at the first received 0xFF, and that byte is the last byte of the flush.
- R3: The frame is sent as six bytes in this order: `0x40 | cmd_idx`, then the argument most-significant byte first, then `{crc7, 1}`. The CRC7 uses polynomial x^7+x^3+1 over the first five bytes. CMD0 with argument 0 ends in 0x95, and CMD8 with argument 0x1AA ends in 0x87.
- R4: After the frame the engine polls with 0xFF up to 8 times. The first received byte with bit 7 = 0 becomes `r1`.
- R5: If none of the 8 polls returns bit 7 = 0, the engine sets `timeout`, leaves `r1` at 0xFF, sends no pad, and finishes after exactly 8 polls.
- R6: After R1 the engine clocks out `min(ext_cnt, 4)` further bytes. It assembles them most-significant first, right-aligned in `resp_ext`, with the upper bits zero.
- R7: After a received response, exactly one extra 0xFF pad byte is sent. No further requests follow `done`.
- R8: If READY_MAX flush bytes in a row return something other than 0xFF, the engine sets `timeout`, sends no frame, and finishes.
- R9: Each byte uses exactly one request. `spi_req` stays high with a stable `spi_txd` until `spi_ack`, then drops for at least one cycle.
- R10: `done` is a single-cycle pulse. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an exchange (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| ext_cnt | input | 3 | Extra response bytes after R1 (values above 4 act as 4) |
| spi_req | output | 1 | Byte transfer request |
| spi_txd | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Transfer complete, `spi_rxd` valid |
| spi_rxd | input | 8 | Byte received from the card |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last exchange ended without a ready card or without R1 |
| r1 | output | 8 | R1 response byte |
| resp_ext | output | 32 | Extended response, right-aligned |

## Verification
A wrong state or a miscounted byte index inside the engine shows up first in the transmitted byte stream. The symptom is a frame byte out of place, a non-0xFF byte in a flush or poll slot, or a missing or doubled pad. That stream is recorded per transfer and compared in full at each `done`. Errors in the poll or flush bounds show up as a wrong total byte count or a wrong `timeout` within the same exchange. Errors in capture show up as a wrong `r1` or `resp_ext` at that `done`. Handshake slips are caught on the cycle after they occur.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_FRAME,
        ST_POLL,
        ST_EXT,
        ST_PAD,
        ST_FINISH
    } eng_state_t;

    localparam int          FRAME_BYTES = 6;
    localparam logic [7:0]  IDLE_BYTE   = 8'hFF;
    localparam logic [1:0]  START_BITS  = 2'b01;
endpackage

// File: rtl/sd_crc7.sv
module sd_crc7 #(
    parameter int DATA_BITS = 40
) (
    input  logic [DATA_BITS-1:0] data,
    output logic [6:0]           crc
);
    always_comb begin
        logic [6:0] acc;
        logic       fb;
        acc = 7'd0;
        for (int i = DATA_BITS - 1; i >= 0; i--) begin
            fb  = data[i] ^ acc[6];
            acc = {acc[5:0], 1'b0};
            if (fb) acc = acc ^ 7'h09;
        end
        crc = acc;
    end
endmodule

// File: rtl/sd_frame_builder.sv
module sd_frame_builder
    import sd_cmd_pkg::*;
#(
    parameter int ARG_BYTES = 4
) (
    input  logic [5:0]             idx,
    input  logic [8*ARG_BYTES-1:0] arg,
    input  logic [2:0]             sel,
    output logic [7:0]             byte_o
);
    localparam int HEAD_BITS = 8 + 8 * ARG_BYTES;

    logic [7:0] frame [0:ARG_BYTES+1];
    logic [6:0] crc;

    sd_crc7 #(.DATA_BITS(HEAD_BITS)) u_crc (
        .data ({START_BITS, idx, arg}),
        .crc  (crc)
    );

    assign frame[0] = {START_BITS, idx};
    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_arg
        assign frame[g+1] = arg[8*(ARG_BYTES-g)-1 -: 8];
    end
    assign frame[ARG_BYTES+1] = {crc, 1'b1};

    always_comb begin
        byte_o = IDLE_BYTE;
        for (int k = 0; k < ARG_BYTES + 2; k++) begin
            if (sel == 3'(k)) byte_o = frame[k];
        end
    end
endmodule

// File: rtl/sd_resp_shift.sv
module sd_resp_shift #(
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [8*BYTES-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout <= '0;
        else if (clr)   dout <= '0;
        else if (shift) dout <= {dout[8*BYTES-9:0], din};
    end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int READY_MAX = 64,
    parameter int R1_POLLS  = 8,
    parameter int EXT_MAX   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [5:0]                     cmd_idx,
    input  logic [31:0]                    cmd_arg,
    input  logic [$clog2(EXT_MAX+1)-1:0]   ext_cnt,
    output logic                           spi_req,
    output logic [7:0]                     spi_txd,
    input  logic                           spi_ack,
    input  logic [7:0]                     spi_rxd,
    output logic                           busy,
    output logic                           done,
    output logic                           timeout,
    output logic [7:0]                     r1,
    output logic [8*EXT_MAX-1:0]           resp_ext
);
    localparam int CNT_MAX = (READY_MAX > R1_POLLS) ? READY_MAX : R1_POLLS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int EXT_W   = $clog2(EXT_MAX + 1);

    eng_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [5:0]       idx_q;
    logic [31:0]      arg_q;
    logic [EXT_W-1:0] ext_q;
    logic             req_q;
    logic             xfer;
    logic             rx_idle, rx_r1;
    logic             last_flush, last_poll, last_frame, last_ext;
    logic [7:0]       frame_byte;
    logic             resp_clr, resp_shift;

    assign xfer       = req_q && spi_ack;
    assign rx_idle    = (spi_rxd == IDLE_BYTE);
    assign rx_r1      = !spi_rxd[7];
    assign last_flush = (cnt_q == CNT_W'(READY_MAX - 1));
    assign last_poll  = (cnt_q == CNT_W'(R1_POLLS - 1));
    assign last_frame = (cnt_q == CNT_W'(FRAME_BYTES - 1));
    assign last_ext   = ((cnt_q + CNT_W'(1)) == CNT_W'(ext_q));

    sd_frame_builder #(.ARG_BYTES(4)) u_frame (
        .idx    (idx_q),
        .arg    (arg_q),
        .sel    (cnt_q[2:0]),
        .byte_o (frame_byte)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FLUSH;
            ST_FLUSH:  if (xfer) begin
                           if (rx_idle)         state_d = ST_FRAME;
                           else if (last_flush) state_d = ST_FINISH;
                       end
            ST_FRAME:  if (xfer && last_frame) state_d = ST_POLL;
            ST_POLL:   if (xfer) begin
                           if (rx_r1)          state_d = (ext_q == '0) ? ST_PAD : ST_EXT;
                           else if (last_poll) state_d = ST_FINISH;
                       end
            ST_EXT:    if (xfer && last_ext) state_d = ST_PAD;
            ST_PAD:    if (xfer) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register, byte counter and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            arg_q   <= '0;
            ext_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)  cnt_q <= '0;
            else if (xfer)           cnt_q <= cnt_q + CNT_W'(1);
            if (state_q == ST_IDLE && start) begin
                idx_q <= cmd_idx;
                arg_q <= cmd_arg;
                ext_q <= (ext_cnt > EXT_W'(EXT_MAX)) ? EXT_W'(EXT_MAX) : ext_cnt;
            end
        end
    end

    // Outputs: request, status and R1 capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            timeout <= 1'b0;
            r1      <= IDLE_BYTE;
        end else begin
            if (xfer)
                req_q <= 1'b0;
            else if (!req_q && state_q inside {ST_FLUSH, ST_FRAME, ST_POLL, ST_EXT, ST_PAD})
                req_q <= 1'b1;

            if (state_q == ST_IDLE && start) begin
                timeout <= 1'b0;
                r1      <= IDLE_BYTE;
            end else if (xfer && state_q == ST_FLUSH && !rx_idle && last_flush) begin
                timeout <= 1'b1;
            end else if (xfer && state_q == ST_POLL) begin
                if (rx_r1)          r1      <= spi_rxd;
                else if (last_poll) timeout <= 1'b1;
            end
        end
    end

    assign resp_clr   = (state_q == ST_IDLE) && start;
    assign resp_shift = xfer && (state_q == ST_EXT);

    sd_resp_shift #(.BYTES(EXT_MAX)) u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (resp_clr),
        .shift (resp_shift),
        .din   (spi_rxd),
        .dout  (resp_ext)
    );

    assign spi_req = req_q;
    assign spi_txd = (state_q == ST_FRAME) ? frame_byte : IDLE_BYTE;
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FINISH);

    // Assertions
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_txd)));

    assert_req_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && spi_ack) |=> !spi_req);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fill_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && state_q != ST_FRAME) |-> (spi_txd == IDLE_BYTE));

    assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> (cnt_q < CNT_W'(R1_POLLS)));

    assert_flush_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (cnt_q < CNT_W'(READY_MAX)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_req);
endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
    localparam int RMAX = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic [2:0]  ext_cnt = '0;
    logic        spi_req;
    logic [7:0]  spi_txd;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rxd = 8'hFF;
    logic        busy, done, timeout;
    logic [7:0]  r1;
    logic [31:0] resp_ext;

    int checks = 0;
    int errors = 0;

    logic [7:0] rx_script [0:63];
    logic [7:0] tx_log    [0:63];
    int         n_script = 0;
    int         n_xfer   = 0;

    always #10 clk = ~clk;

    sd_cmd_engine #(.READY_MAX(RMAX), .R1_POLLS(8), .EXT_MAX(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .ext_cnt(ext_cnt), .spi_req(spi_req),
        .spi_txd(spi_txd), .spi_ack(spi_ack), .spi_rxd(spi_rxd),
        .busy(busy), .done(done), .timeout(timeout), .r1(r1),
        .resp_ext(resp_ext)
    );

    // Card and SPI shifter model: replies from a script, logs each byte sent
    initial begin
        forever begin
            @(negedge clk);
            if (spi_req) begin
                repeat ($urandom % 3) @(negedge clk);
                if (n_xfer < 64) tx_log[n_xfer] = spi_txd;
                spi_rxd = (n_xfer < n_script) ? rx_script[n_xfer] : 8'hFF;
                spi_ack = 1'b1;
                n_xfer++;
                @(negedge clk);
                spi_ack = 1'b0;
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_crc(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] m;
        logic [6:0]  c;
        m = {2'b01, idx, arg};
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            if (m[i] ^ c[6]) c = {c[5:0], 1'b0} ^ 7'h09;
            else             c = {c[5:0], 1'b0};
        end
        return {c, 1'b1};
    endfunction

    function automatic logic [7:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg, input int k);
        case (k)
            0:       return {2'b01, idx};
            1:       return arg[31:24];
            2:       return arg[23:16];
            3:       return arg[15:8];
            4:       return arg[7:0];
            default: return exp_crc(idx, arg);
        endcase
    endfunction

    task automatic run_txn(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] ext,
                           input int nbusy, input int lat, input logic [7:0] r1v,
                           input logic [31:0] extv, input bit intrude);
        int          e, p, exp_n, fstart, bad_frame, bad_fill, n_after;
        bit          exp_to, flush_to;
        logic [7:0]  exp_r1;
        logic [31:0] exp_resp;
        e = (ext > 3'd4) ? 4 : int'(ext);
        p = 0;
        for (int k = 0; k < nbusy; k++) begin rx_script[p] = 8'($urandom % 255); p++; end
        rx_script[p] = 8'hFF; p++;
        for (int k = 0; k < 6; k++) begin rx_script[p] = 8'hFF; p++; end
        for (int k = 0; k < lat; k++) begin rx_script[p] = 8'h80 | 8'($urandom); p++; end
        if (lat < 8) begin
            rx_script[p] = r1v; p++;
            for (int k = e - 1; k >= 0; k--) begin rx_script[p] = extv[8*k +: 8]; p++; end
        end
        rx_script[p] = 8'hFF; p++;
        n_script = p;
        n_xfer   = 0;

        @(negedge clk);
        cmd_idx = idx; cmd_arg = arg; ext_cnt = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            cmd_idx = ~idx; cmd_arg = ~arg; ext_cnt = 3'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);

        flush_to = (nbusy >= RMAX);
        exp_to   = flush_to || (lat >= 8);
        exp_r1   = exp_to ? 8'hFF : r1v;
        exp_resp = 32'd0;
        for (int k = 0; k < e; k++) exp_resp[8*k +: 8] = extv[8*k +: 8];
        if (exp_to) exp_resp = 32'd0;
        if (flush_to)      exp_n = RMAX;
        else if (lat >= 8) exp_n = nbusy + 1 + 6 + 8;
        else               exp_n = nbusy + 1 + 6 + lat + 1 + e + 1;
        fstart = flush_to ? 64 : nbusy + 1;

        chk(timeout == exp_to, "R5/R8 timeout flag", 32'(timeout), 32'(exp_to));
        chk(r1 == exp_r1, "R4 r1 value", 32'(r1), 32'(exp_r1));
        chk(resp_ext == exp_resp, "R6 extended response", resp_ext, exp_resp);
        chk(n_xfer == exp_n, "R7 byte count per exchange", 32'(n_xfer), 32'(exp_n));

        bad_frame = 0; bad_fill = 0;
        for (int k = 0; k < exp_n && k < 64; k++) begin
            if (k >= fstart && k < fstart + 6) begin
                if (tx_log[k] !== exp_frame(idx, arg, k - fstart)) bad_frame++;
            end else if (tx_log[k] !== 8'hFF) bad_fill++;
        end
        if (!flush_to)
            chk(bad_frame == 0, "R3 frame bytes (R10 start ignored when busy)", 32'(bad_frame), 32'd0);
        chk(bad_fill == 0, "R2 fill bytes are 0xFF", 32'(bad_fill), 32'd0);

        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 done single pulse", {30'd0, done, busy}, 32'd0);
        n_after = n_xfer;
        repeat (6) @(negedge clk);
        chk(n_xfer == n_after, "R7 no request after done", 32'(n_xfer), 32'(n_after));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(spi_req == 0 && busy == 0 && done == 0 && timeout == 0,
            "R1 reset control outputs", {28'd0, spi_req, busy, done, timeout}, 32'd0);
        chk(r1 == 8'hFF && resp_ext == 0, "R1 reset data outputs", {r1, resp_ext[23:0]}, 32'hFF000000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed CRC references (R3)
        chk(exp_crc(6'd0, 32'd0) == 8'h95, "R3 crc reference CMD0", 32'(exp_crc(6'd0, 32'd0)), 32'h95);
        chk(exp_crc(6'd8, 32'h1AA) == 8'h87, "R3 crc reference CMD8", 32'(exp_crc(6'd8, 32'h1AA)), 32'h87);

        run_txn(6'd0,  32'd0,        3'd0, 0, 1, 8'h01, 32'd0,        1'b0); // R3 CMD0
        run_txn(6'd8,  32'h1AA,      3'd4, 2, 0, 8'h01, 32'h000001AA, 1'b0); // R3 R6 CMD8
        run_txn(6'd58, 32'd0,        3'd4, 1, 7, 8'h00, 32'hC0FF8000, 1'b0); // R4 last poll
        run_txn(6'd55, 32'd0,        3'd0, 3, 8, 8'h01, 32'd0,        1'b0); // R5 poll timeout
        run_txn(6'd1,  32'd0,        3'd0, 20, 0, 8'h01, 32'd0,       1'b0); // R8 flush timeout
        run_txn(6'd13, 32'h12345678, 3'd2, 15, 2, 8'h05, 32'h0000ABCD, 1'b0); // R2 long flush
        run_txn(6'd41, 32'h40000000, 3'd5, 0, 0, 8'h00, 32'hDEADBEEF, 1'b0); // R6 clamp
        run_txn(6'd9,  32'hA5A55A5A, 3'd1, 4, 3, 8'h3F, 32'h00000077, 1'b1); // R10 start ignored

        for (int t = 0; t < 40; t++) begin
            run_txn(6'($urandom), $urandom, 3'($urandom % 6), int'($urandom % 6),
                    int'($urandom % 10), 8'($urandom % 128), $urandom, 1'($urandom % 4 == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule